// File: doc/BRIEF.md
# Mantissa-Exponent Bit-Rate Tick Generator

This block derives the transmit bit clock of a serial transmitter from the reference clock alone. Two configuration fields set the rate: an 8-bit mantissa and a 4-bit exponent. A 28-bit phase accumulator adds an increment of `(256 + mantissa) << exponent` on every reference cycle while the block is enabled. Every carry out of the accumulator's top bit marks one bit period, and the block reports it as a single-cycle tick. The tick rate is therefore `f_ref * (256 + mantissa) * 2^exponent / 2^28`, and it scales directly with the reference frequency.

A small two-state controller follows the enable input. In `ST_IDLE` the accumulator is held at zero and no ticks appear. The transition `IDLE->RUN` happens at the first edge where enable is sampled high, and accumulation starts at that same edge. In `ST_RUN` the accumulator advances on every cycle. The transition `RUN->IDLE` happens at the first edge where enable is sampled low, and that edge clears the accumulator. The mantissa and exponent may change at any time. A new value is used from the next accumulation onward, and the phase already collected is kept.

Top module: `drate_tick_gen`

## Requirements
- R1: While `rst_ni` is low, `tick_o` is 0 and the accumulator is cleared, so the first carry after reset needs a full bit period.
- R2: At every rising edge with `en_i` high, the 28-bit accumulator advances by `(256 + mant_i) << expo_i`. `tick_o` is high during the cycle after that edge exactly when the addition carried out of bit 27.
- R3: `tick_o` is never high on two consecutive cycles. The largest increment (255, 15) is smaller than 2^27.
- R4: At an edge with `en_i` low, the accumulator is cleared and `tick_o` is 0 in the following cycle. The first accumulation after a restart begins from zero, so it produces no tick.
- R5: A change of `mant_i` or `expo_i` while running takes effect at the next edge and does not clear the accumulated phase.
- R6: When the block starts from a cleared accumulator, the number of ticks in the first N enabled cycles is `floor(N * (256 + mant) * 2^expo / 2^28)`.
- R7: With the largest setting (mantissa 255, exponent 15), the first tick after a restart is seen after edge `ceil(2^28 / 16744448)` = 17.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable; low holds the accumulator at zero |
| mant_i | input | 8 | Rate mantissa; a leading one is implied above it |
| expo_i | input | 4 | Rate exponent; the power-of-two shift of the increment |
| tick_o | output | 1 | One-cycle bit-rate tick |

## Verification
The bench targets the fastest setting. There, an increment that loses its implied leading one or is shifted one place too far moves the first tick away from edge 17, or produces ticks back to back. It also targets restarts after an enable dropout. A design that kept the old phase across a dropout would tick early after re-enable, and one that was late in clearing would show a stray tick in the disabled window. Configuration changes in the middle of a period are driven at random. A design that reset the accumulator on a change would lose phase, and its tick positions would drift from the bench's model. Long constant-rate runs at low exponents test the 2^28 denominator through the tick count, which an off-by-one carry position would double or halve.

// File: rtl/drate_pkg.sv
package drate_pkg;

    localparam int unsigned DEF_MANT_W = 8;
    localparam int unsigned DEF_EXP_W  = 4;
    localparam int unsigned DEF_ACC_W  = 28;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } drate_state_e;

endpackage

// File: rtl/drate_incr.sv
module drate_incr #(
    parameter int unsigned MANT_W = drate_pkg::DEF_MANT_W,
    parameter int unsigned EXP_W  = drate_pkg::DEF_EXP_W,
    parameter int unsigned ACC_W  = drate_pkg::DEF_ACC_W
) (
    input  logic [MANT_W-1:0] mant_i,
    input  logic [EXP_W-1:0]  expo_i,
    output logic [ACC_W-1:0]  incr_o
);
    // Widest increment: mantissa with its implied one, shifted by the top exponent.
    localparam int unsigned BASE_W = MANT_W + 1;
    localparam int unsigned MAX_SH = (1 << EXP_W) - 1;
    localparam int unsigned INC_W  = BASE_W + MAX_SH;

    logic [BASE_W-1:0] base;
    logic [INC_W-1:0]  shifted;

    always_comb begin
        base    = {1'b1, mant_i};
        shifted = INC_W'(base) << expo_i;
    end

    generate
        if (INC_W <= ACC_W) begin : g_fit
            assign incr_o = ACC_W'(shifted);
        end else begin : g_trunc
            assign incr_o = shifted[ACC_W-1:0];
        end
    endgenerate

endmodule

// File: rtl/drate_accum.sv
module drate_accum #(
    parameter int unsigned ACC_W = drate_pkg::DEF_ACC_W
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             step_i,
    input  logic [ACC_W-1:0] incr_i,
    output logic             carry_o
);
    logic [ACC_W-1:0] phase_q;
    logic [ACC_W:0]   sum;

    always_comb begin
        sum = {1'b0, phase_q} + {1'b0, incr_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            phase_q <= '0;
            carry_o <= 1'b0;
        end else if (step_i) begin
            phase_q <= sum[ACC_W-1:0];
            carry_o <= sum[ACC_W];
        end else begin
            phase_q <= '0;
            carry_o <= 1'b0;
        end
    end

endmodule

// File: rtl/drate_tick_gen.sv
module drate_tick_gen
    import drate_pkg::*;
#(
    parameter int unsigned MANT_W = DEF_MANT_W,
    parameter int unsigned EXP_W  = DEF_EXP_W,
    parameter int unsigned ACC_W  = DEF_ACC_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              en_i,
    input  logic [MANT_W-1:0] mant_i,
    input  logic [EXP_W-1:0]  expo_i,
    output logic              tick_o
);
    drate_state_e state_q, state_d;
    logic [ACC_W-1:0] incr;
    logic             carry;

    // Next-state choice
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (en_i)  state_d = ST_RUN;
            ST_RUN:  if (!en_i) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    // Outputs
    always_comb begin
        tick_o = 1'b0;
        unique case (state_q)
            ST_IDLE: tick_o = 1'b0;
            ST_RUN:  tick_o = carry;
            default: tick_o = 1'b0;
        endcase
    end

    drate_incr #(
        .MANT_W (MANT_W),
        .EXP_W  (EXP_W),
        .ACC_W  (ACC_W)
    ) i_incr (
        .mant_i (mant_i),
        .expo_i (expo_i),
        .incr_o (incr)
    );

    drate_accum #(
        .ACC_W (ACC_W)
    ) i_accum (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .step_i  (en_i),
        .incr_i  (incr),
        .carry_o (carry)
    );

endmodule

// File: rtl/drate_tick_chk.sv
module drate_tick_chk
    import drate_pkg::*;
(
    input logic         clk,
    input logic         rst_n,
    input logic         en,
    input logic         tick,
    input drate_state_e state
);
    // R1: reset keeps the tick low
    p_reset_quiet_r1: assert property (@(posedge clk) !rst_n |=> !tick)
        else $error("p_reset_quiet_r1");

    // R3: ticks never touch
    p_single_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick)
        else $error("p_single_tick_r3");

    // R4: a disabled edge leaves no tick behind
    p_disable_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !tick)
        else $error("p_disable_quiet_r4");

    // R4: the first accumulation after a restart cannot carry
    p_restart_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && state == ST_IDLE) |=> !tick)
        else $error("p_restart_quiet_r4");

    // R2: running state follows the sampled enable
    p_state_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> (state == ST_RUN))
        else $error("p_state_follow_r2");

endmodule

bind drate_tick_gen drate_tick_chk i_chk (
    .clk   (clk_i),
    .rst_n (rst_ni),
    .en    (en_i),
    .tick  (tick_o),
    .state (state_q)
);

// File: tb/test_drate_tick_gen.sv
module test_drate_tick_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [7:0] mant = '0;
    logic [3:0] expo = '0;
    logic       tick;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Bench model state
    longint unsigned m_acc = 0;
    bit              m_tick = 0;
    bit              prev_tick = 0;

    always #10 clk = ~clk;

    drate_tick_gen i_drate_tick_gen (
        .clk_i  (clk),
        .rst_ni (rst_n),
        .en_i   (en),
        .mant_i (mant),
        .expo_i (expo),
        .tick_o (tick)
    );

    function automatic longint unsigned incr_of(input logic [7:0] m, input logic [3:0] e);
        return (longint'(256) + longint'(m)) << e;
    endfunction

    function automatic longint unsigned ticks_in(input longint unsigned n, input longint unsigned inc);
        return (n * inc) >> 28;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        longint unsigned s;
        if (!rst_n) begin
            m_acc  = 0;
            m_tick = 0;
        end else if (en) begin
            s      = m_acc + incr_of(mant, expo);
            m_tick = s[28];
            m_acc  = s & 64'h0FFF_FFFF;
        end else begin
            m_acc  = 0;
            m_tick = 0;
        end
    end

    task automatic check(input string req, input longint unsigned act, input longint unsigned exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // One edge, then compare at the falling edge
    task automatic step(input string req, output bit t);
        @(posedge clk);
        @(negedge clk);
        check(req, tick, m_tick);
        if (prev_tick && tick) check("R3", 1, 0);
        prev_tick = tick;
        t = tick;
    endtask

    task automatic idle(input int n);
        bit t;
        en = 1'b0;
        for (int i = 0; i < n; i++) begin
            step("R4", t);
            check("R4", t, 0);
        end
    endtask

    // Start from cleared phase, run n edges at fixed setting, count ticks
    task automatic run_const(input string req, input logic [7:0] m, input logic [3:0] e, input int n);
        bit t;
        int cnt = 0;
        mant = m; expo = e; en = 1'b1;
        for (int i = 0; i < n; i++) begin
            step(req, t);
            if (t) cnt++;
        end
        check("R6", cnt, ticks_in(n, incr_of(m, e)));
    endtask

    initial begin
        #(20 * 190000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        bit t;
        int first;
        void'($urandom(32'd20240611));
        en = 1'b1; mant = 8'hFF; expo = 4'hF;
        repeat (3) @(negedge clk);
        check("R1", tick, 0);
        @(negedge clk);
        rst_n = 1'b1;
        en = 1'b0;
        idle(3);

        // R7: fastest setting, first tick position
        mant = 8'hFF; expo = 4'hF; en = 1'b1;
        first = 0;
        for (int i = 1; i <= 40; i++) begin
            step("R2", t);
            if (t && first == 0) first = i;
        end
        check("R7", first, 17);
        idle(4);

        run_const("R2", 8'hFF, 4'hF, 3000);
        idle(5);
        run_const("R2", 8'h00, 4'd12, 4000);
        idle(2);
        run_const("R2", 8'h80, 4'd10, 6000);
        idle(1);
        // R6: low exponent, long period
        run_const("R6", 8'h00, 4'd6, 17000);
        idle(3);

        // R4: restart after dropout in mid-period
        mant = 8'h3C; expo = 4'd14; en = 1'b1;
        repeat (23) step("R4", t);
        idle(2);
        run_const("R4", 8'h3C, 4'd14, 500);

        // R5: setting changes while running, phase kept
        for (int seg = 0; seg < 40; seg++) begin
            int len = 200 + int'($urandom_range(0, 1500));
            mant = 8'($urandom_range(0, 255));
            expo = 4'($urandom_range(9, 15));
            en   = 1'b1;
            for (int i = 0; i < len; i++) step("R5", t);
            if ($urandom_range(0, 3) == 0) idle(int'($urandom_range(1, 4)));
        end

        // R5: change exactly one edge into a run
        idle(2);
        mant = 8'h10; expo = 4'd15; en = 1'b1;
        step("R5", t);
        mant = 8'hF0; expo = 4'd13;
        for (int i = 0; i < 2000; i++) step("R5", t);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule